// File: doc/BRIEF.md
# Two-Wire Slave with Upstream Report Staging

This block is a two-wire serial bus slave that lets an external microcontroller exchange a few bytes with the USB side of an audio controller. Its bus address is fixed by a parameter. The microcontroller writes into two upstream byte registers and reads one downstream byte. The USB side loads that downstream byte through a load strobe. The block samples SCL and SDA with the system clock, well above the 400 kbit/s bus rate. Each line passes through a synchronizer and a glitch filter before any edge is detected.

Each stored byte causes the block to stage a three-byte upstream report and raise a pending flag. A change of the button status does the same. The report carries the button status in the low byte, then the even-address register, then the odd-address register. The consumer takes the report with a valid/ack handshake. A new trigger that arrives while a report is still pending overwrites the staged bytes and leaves the flag set.

Top module: `mcu_link_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0111000. On a match it pulls SDA low during the ninth clock of the address byte. On a mismatch it leaves SDA released for the rest of the transfer, stores nothing and stages no report until the next START or STOP.
- R2: In a write (eighth address bit 0), the first data byte is a pointer. Only its bit 0 is used: 0 selects the even register and 1 selects the odd register. A write that carries only the pointer stores nothing and stages no report.
- R3: The second data byte of a write is stored into the selected register. Every further byte goes to the other register, because the pointer toggles after each store.
- R4: The slave acknowledges every data byte of an addressed write by pulling SDA low during its ninth clock.
- R5: In a read (eighth address bit 1), every byte returns the downstream byte MSB first, whatever the pointer holds. The slave changes SDA only while SCL is low. After a master NACK it keeps SDA released.
- R6: Every stored byte sets `rpt_valid_o` one clock after the store. `rpt_data_o` then holds the buttons in bits 7:0, the even register in bits 15:8 and the odd register in bits 23:16, including the byte just stored.
- R7: A change of `btn_i` restages the report with the new button value and sets `rpt_valid_o` at the next clock edge.
- R8: `rpt_ack_i` while `rpt_valid_o` is high clears the flag at the next edge, unless a new trigger arrives in that cycle. A trigger while the flag is pending overwrites `rpt_data_o` and the flag stays high.
- R9: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A repeated START without a STOP begins a new address phase.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks, measured after the synchronizer, has no effect on the bus decoding.
- R11: After reset, SDA is released, `rpt_valid_o` is 0, `rpt_data_o` is 0, and both registers and the downstream byte are 0.
- R12: A pulse on `dn_load_i` copies `dn_data_i` into the downstream byte returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| btn_i | input | BTN_W | Button status byte |
| dn_load_i | input | 1 | Load strobe for the downstream byte |
| dn_data_i | input | 8 | Downstream byte value |
| rpt_valid_o | output | 1 | Upstream report pending |
| rpt_data_o | output | BTN_W+16 | Staged report {odd, even, buttons} |
| rpt_ack_i | input | 1 | Consumer takes the pending report |

## Verification
Any bus effect appears after the synchronizer and filter delay, about `SYNC_STAGES + FILT_LEN + 1` clocks after a line change. The bench holds each SCL phase for 20 clocks, so it samples the slave's SDA drive and the master's bits mid-phase, well clear of that delay. A stored byte shows on the report port one clock after the ack-clock fall, and the bench reads the report only after the STOP. Button changes and acks act at the next edge, so those checks sample two clocks after the stimulus, away from the clock edge.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_ADDR_ACK,
    BS_WR,
    BS_WR_ACK,
    BS_RD,
    BS_RD_ACK,
    BS_SKIP
  } bus_state_t;
endpackage

// File: rtl/tws_line_filter.sv
module tws_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   sync_last;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{IDLE_LVL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // Output follows the synchronized line only after FILT_LEN differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      clean_o <= IDLE_LVL;
    end else if (sync_last == clean_o) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      clean_o <= sync_last;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R10: filtered level only moves to a value the synchronizer already held
  assert_filter_follow_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean_o) |-> (clean_o == $past(sync_last)));
endmodule

// File: rtl/tws_bus_engine.sv
module tws_bus_engine
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] dn_byte,
  output logic              drive_low,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int BCW = $clog2(BYTE_W + 1);

  bus_state_t        state;
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [BCW-1:0]    bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              first_byte, ptr, rw_bit, m_nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state      <= BS_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      first_byte <= 1'b1;
      ptr        <= 1'b0;
      rw_bit     <= 1'b0;
      m_nack     <= 1'b0;
      drive_low  <= 1'b0;
      wr_sel     <= 1'b0;
      wr_data    <= '0;
    end else if (start_c) begin
      state      <= BS_ADDR;
      bit_cnt    <= '0;
      first_byte <= 1'b1;
      drive_low  <= 1'b0;
    end else if (stop_c) begin
      state     <= BS_IDLE;
      drive_low <= 1'b0;
    end else begin
      case (state)
        BS_ADDR, BS_WR: begin
          if (scl_rise && bit_cnt != BCW'(BYTE_W)) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == BCW'(BYTE_W)) begin
            bit_cnt <= '0;
            if (state == BS_ADDR) begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                drive_low <= 1'b1;
                rw_bit    <= rx_sh[0];
                state     <= BS_ADDR_ACK;
              end else begin
                state <= BS_SKIP;
              end
            end else begin
              drive_low <= 1'b1;
              state     <= BS_WR_ACK;
              if (first_byte) begin
                ptr        <= rx_sh[0];
                first_byte <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_sel  <= ptr;
                wr_data <= rx_sh;
                ptr     <= ~ptr;
              end
            end
          end
        end
        BS_ADDR_ACK: if (scl_fall) begin
          bit_cnt <= '0;
          if (rw_bit) begin
            state     <= BS_RD;
            tx_sh     <= dn_byte;
            drive_low <= ~dn_byte[BYTE_W-1];
          end else begin
            state     <= BS_WR;
            drive_low <= 1'b0;
          end
        end
        BS_WR_ACK: if (scl_fall) begin
          drive_low <= 1'b0;
          state     <= BS_WR;
        end
        BS_RD: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == BCW'(BYTE_W)) begin
              drive_low <= 1'b0;
              state     <= BS_RD_ACK;
            end else begin
              tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
              drive_low <= ~tx_sh[BYTE_W-2];
            end
          end
        end
        BS_RD_ACK: begin
          if (scl_rise) begin
            m_nack <= sda_f;
          end else if (scl_fall) begin
            if (m_nack) begin
              state <= BS_SKIP;
            end else begin
              state     <= BS_RD;
              bit_cnt   <= '0;
              tx_sh     <= dn_byte;
              drive_low <= ~dn_byte[BYTE_W-1];
            end
          end
        end
        default: drive_low <= 1'b0;
      endcase
    end
  end

  // R1: an idle or non-addressed slave never pulls SDA
  assert_released_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (state == BS_IDLE || state == BS_SKIP) |-> !drive_low);

  // R4: a store coincides with the slave acknowledging that byte
  assert_store_acked_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> drive_low);

  // R5: the slave starts pulling SDA only while the filtered SCL is low
  assert_pull_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> !scl_f);
endmodule

// File: rtl/tws_report_stage.sv
module tws_report_stage
  import tws_pkg::*;
#(
  parameter int BTN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BTN_W-1:0]      btn_i,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic                  dn_load,
  input  logic [BYTE_W-1:0]     dn_data,
  input  logic                  rpt_ack,
  output logic                  rpt_valid,
  output logic [BTN_W+15:0]     rpt_data,
  output logic [BYTE_W-1:0]     dn_byte
);
  localparam int NREG = 2;

  logic [BYTE_W-1:0] bank_q  [NREG];
  logic [BYTE_W-1:0] bank_nx [NREG];
  logic [BTN_W-1:0]  btn_q;
  logic              trig;

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign bank_nx[g] = (wr_en && (int'(wr_sel) == g)) ? wr_data : bank_q[g];
    always_ff @(posedge clk) begin
      if (rst) bank_q[g] <= '0;
      else     bank_q[g] <= bank_nx[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) btn_q <= '0;
    else     btn_q <= btn_i;
  end

  assign trig = wr_en | (btn_i != btn_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_valid <= 1'b0;
      rpt_data  <= '0;
    end else if (trig) begin
      rpt_valid <= 1'b1;
      rpt_data  <= {bank_nx[1], bank_nx[0], btn_i};
    end else if (rpt_ack) begin
      rpt_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          dn_byte <= '0;
    else if (dn_load) dn_byte <= dn_data;
  end

  // R6: a store raises the pending flag on the next edge
  assert_store_pending_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rpt_valid);

  // R6: an even store lands in report bits 15:8
  assert_even_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> (rpt_data[BTN_W+7:BTN_W] == $past(wr_data)));

  // R8: ack without a new trigger drops the flag
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_ack && !trig) |=> !rpt_valid);

  // R8: an untaken report stays pending
  assert_pending_held_R8: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !rpt_ack) |=> rpt_valid);
endmodule

// File: rtl/mcu_link_slave.sv
module mcu_link_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0111000,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 4,
  parameter int         BTN_W       = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [BTN_W-1:0]   btn_i,
  input  logic               dn_load_i,
  input  logic [7:0]         dn_data_i,
  output logic               rpt_valid_o,
  output logic [BTN_W+15:0]  rpt_data_o,
  input  logic               rpt_ack_i
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic              wr_en, wr_sel;
  logic [BYTE_W-1:0] wr_data, dn_byte;

  assign raw_lines = {sda_i, scl_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    tws_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .IDLE_LVL   (1'b1)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_lines[i]),
      .clean_o(clean_lines[i])
    );
  end

  tws_bus_engine #(
    .DEV_ADDR(DEV_ADDR)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (clean_lines[0]),
    .sda_f    (clean_lines[1]),
    .dn_byte  (dn_byte),
    .drive_low(sda_pull_o),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data)
  );

  tws_report_stage #(
    .BTN_W(BTN_W)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .btn_i    (btn_i),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .dn_load  (dn_load_i),
    .dn_data  (dn_data_i),
    .rpt_ack  (rpt_ack_i),
    .rpt_valid(rpt_valid_o),
    .rpt_data (rpt_data_o),
    .dn_byte  (dn_byte)
  );
endmodule

// File: tb/mcu_link_slave_test.sv
`timescale 1ns/1ps
module mcu_link_slave_test;
  localparam int Q = 20;
  localparam logic [6:0] ADDR = 7'b0111000;
  // vector: [39:32] pointer, [31:24] data count, [23:16] [15:8] [7:0] data
  localparam int NVEC = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    40'h00_01_3C_00_00,
    40'h01_01_A5_00_00,
    40'hFE_02_12_34_00,
    40'h83_03_56_78_9A,
    40'h40_01_FF_00_00,
    40'h01_02_00_81_00
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [7:0] btn = 8'h00;
  logic dn_load = 1'b0;
  logic [7:0] dn_data = 8'h00;
  logic rpt_valid, rpt_ack = 1'b0;
  logic [23:0] rpt_data;
  logic glitch_en = 1'b0;
  wire sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_even = 8'h00, exp_odd = 8'h00;

  always #2.5 clk = ~clk;

  mcu_link_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .btn_i(btn), .dn_load_i(dn_load), .dn_data_i(dn_data),
    .rpt_valid_o(rpt_valid), .rpt_data_o(rpt_data), .rpt_ack_i(rpt_ack));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; tick(Q / 2);
    if (glitch_en) begin scl = 1'b1; tick(2); scl = 1'b0; end
    tick(Q / 2);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    acked = ~b;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(nack);
  endtask

  task automatic take_report();
    rpt_ack = 1'b1; tick(1);
    rpt_ack = 1'b0; tick(1);
  endtask

  initial begin
    logic a;
    logic [7:0] ptr, cnt, got;
    logic [23:0] dat;
    logic sel;

    tick(5);
    rst = 1'b0; tick(2);
    // R11 reset state
    chk("R11 sda released", {31'd0, sda_pull}, 32'd0);
    chk("R11 valid low", {31'd0, rpt_valid}, 32'd0);
    chk("R11 report zero", {8'd0, rpt_data}, 32'd0);

    // vector table: pointer + data writes, report order (R2 R3 R4 R6)
    for (int v = 0; v < NVEC; v++) begin
      ptr = VEC[v][39:32]; cnt = VEC[v][31:24]; dat = VEC[v][23:0];
      sel = ptr[0];
      bstart();
      wbyte({ADDR, 1'b0}, a); chk("R1 address ack", {31'd0, a}, 32'd1);
      wbyte(ptr, a);          chk("R4 pointer ack", {31'd0, a}, 32'd1);
      for (int k = 0; k < int'(cnt); k++) begin
        wbyte(dat[23-8*k -: 8], a);
        chk("R4 data ack", {31'd0, a}, 32'd1);
        if (sel) exp_odd = dat[23-8*k -: 8];
        else     exp_even = dat[23-8*k -: 8];
        sel = ~sel;
      end
      bstop(); tick(2);
      chk("R6 pending after write", {31'd0, rpt_valid}, 32'd1);
      chk("R3 R6 report bytes", {8'd0, rpt_data}, {8'd0, exp_odd, exp_even, btn});
      take_report();
      chk("R8 ack clears", {31'd0, rpt_valid}, 32'd0);
    end

    // R2 pointer-only write stages nothing
    bstart(); wbyte({ADDR, 1'b0}, a); wbyte(8'h01, a); bstop(); tick(2);
    chk("R2 pointer-only no report", {31'd0, rpt_valid}, 32'd0);

    // R12 + R5 read returns downstream byte twice; pointer ignored; release after NACK
    dn_data = 8'h3C; dn_load = 1'b1; tick(1); dn_load = 1'b0; tick(1);
    bstart();
    wbyte({ADDR, 1'b1}, a); chk("R1 read address ack", {31'd0, a}, 32'd1);
    rbyte(1'b0, got); chk("R12 R5 first read byte", {24'd0, got}, 32'h3C);
    rbyte(1'b1, got); chk("R5 repeated read byte", {24'd0, got}, 32'h3C);
    chk("R5 released after master NACK", {31'd0, sda_pull}, 32'd0);
    bstop(); tick(2);

    // R1 address mismatch: no ack, nothing stored
    bstart();
    wbyte({7'b0111001, 1'b0}, a); chk("R1 mismatch no ack", {31'd0, a}, 32'd0);
    wbyte(8'h00, a); chk("R1 skipped byte no ack", {31'd0, a}, 32'd0);
    wbyte(8'h5A, a);
    bstop(); tick(2);
    chk("R1 mismatch no report", {31'd0, rpt_valid}, 32'd0);

    // R9 repeated START: two write phases without a STOP between them
    bstart();
    wbyte({ADDR, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h11, a);
    bstart();
    wbyte({ADDR, 1'b0}, a); chk("R9 ack after repeated start", {31'd0, a}, 32'd1);
    wbyte(8'h01, a); wbyte(8'h22, a);
    bstop(); tick(2);
    exp_even = 8'h11; exp_odd = 8'h22;
    chk("R9 both phases stored", {8'd0, rpt_data}, {8'd0, exp_odd, exp_even, btn});
    // R1 mismatch did not touch even register (still 11 from this write, not 5A)

    // R8 overwrite while pending: flag stays, data replaced
    bstart(); wbyte({ADDR, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h77, a); bstop(); tick(2);
    exp_even = 8'h77;
    chk("R8 still pending", {31'd0, rpt_valid}, 32'd1);
    chk("R8 overwritten data", {8'd0, rpt_data}, {8'd0, exp_odd, exp_even, btn});
    take_report();

    // R10 short SCL glitches inside every bit are ignored
    glitch_en = 1'b1;
    bstart(); wbyte({ADDR, 1'b0}, a); wbyte(8'h01, a); wbyte(8'hC6, a); bstop();
    glitch_en = 1'b0; tick(2);
    exp_odd = 8'hC6;
    chk("R10 glitch-free store", {8'd0, rpt_data}, {8'd0, exp_odd, exp_even, btn});
    take_report();

    // R7 button change restages at next edge
    btn = 8'h05; tick(2);
    chk("R7 pending on button", {31'd0, rpt_valid}, 32'd1);
    chk("R7 button in report", {8'd0, rpt_data}, {8'd0, exp_odd, exp_even, 8'h05});
    take_report();
    tick(3);
    chk("R7 steady buttons no report", {31'd0, rpt_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule